// File: doc/BRIEF.md
# Registered Sum-of-Products Array with State Feedback

This block is a small programmable logic array for building state machines. It has a programmable AND plane and a fixed OR plane. Every output is the OR of its own group of product terms and is captured in a D flip-flop on the shared clock. A product term may take any primary input or any register output, in true or inverted form. Because the register outputs feed back into the AND plane, the next state can depend on the current state. The registered values leave the block inverted, on active-low pins. A single output-enable controls the drivers of all pins together.

The array contents are a bit map held in a shift chain. The map arrives one bit at a time over a valid/ready stream. The block never applies back-pressure outside reset. `cfg_ready` is high whenever `rst` is low, and a bit is consumed on every rising edge where `cfg_valid` and `cfg_ready` are both high. The source must keep `cfg_bit` stable while `cfg_valid` is high and no transfer has taken place. While `rst` is high, `cfg_ready` is low and nothing is consumed. The registers keep evaluating during a load, so the outputs follow the partly loaded map until the load is complete.

The fuse index of a literal is `(o*PT_PER_OUT + p)*2*(N_IN+N_OUT) + 2*v + c`, where `o` is the output, `p` is the term within that output's group, `v` is the variable and `c` is the polarity. Variables `v < N_IN` are `in_pins[v]` and the rest are register `v-N_IN`. Polarity `c=0` selects the true literal and `c=1` the inverted one. A fuse value of 1 includes that literal in the term.

Top module: `pal_reg_array`

## Requirements
- R1: `cfg_ready` is 1 whenever `rst` is 0 and 0 whenever `rst` is 1; a map bit is consumed only on a rising edge with `cfg_valid` and `cfg_ready` both 1.
- R2: Each consumed bit enters fuse index 0 and every older bit moves up by one index. After N_FUSE transfers, the first bit sent sits at index N_FUSE-1. The map does not change on edges without a transfer.
- R3: A set fuse at `2*v` includes the true value of variable `v` in its term, and a set fuse at `2*v+1` includes the inverted value. Variables 0..N_IN-1 are the inputs, and variables N_IN.. are the register outputs.
- R4: A product term with no set fuse is 0, and a term that includes both polarities of one variable is 0.
- R5: Register `o` is fed only by the OR of terms `o*PT_PER_OUT` to `o*PT_PER_OUT+PT_PER_OUT-1`. A term that is true sets only its own output.
- R6: Every register takes its new value on each rising clock edge, and `pin_n` always equals the bitwise inverse of the registers.
- R7: A synchronous reset clears all registers, so `pin_n` reads all ones whatever the map holds. The map itself is kept across reset.
- R8: `pin_oe` is 1 exactly when `oe_n` is 0. The registers keep updating while the drivers are off.
- R9: Register outputs feed the AND plane, so the next state can depend on the current state (for example, a toggle register `q <= q ^ in`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers and the map chain |
| rst | input | 1 | Synchronous reset of the registers, active high |
| cfg_valid | input | 1 | Map bit on `cfg_bit` is offered |
| cfg_ready | output | 1 | Block accepts a map bit (high outside reset) |
| cfg_bit | input | 1 | Serial map data |
| in_pins | input | N_IN | Primary inputs to the AND plane |
| oe_n | input | 1 | Shared output enable, active low |
| pin_n | output | N_OUT | Inverted register outputs |
| pin_oe | output | 1 | Driver enable for all of `pin_n` |

## Verification
The bench builds the block with its defaults: eight inputs, eight registers and eight terms per output, which gives a 2048-bit map. These values bring within reach full-length serial loads with random stalls, and toggle state machines that span every register. They also allow group-boundary terms such as the last term of output 0 and the first term of output 1. A behavioural model tracks the map and the registers and is compared on every clock. Hand-computed sequences cover polarity, feedback, reset with map retention and driver disable.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_COMP = 1'b1
  } pol_e;

  localparam int unsigned LIT_STRIDE = 2;

  function automatic int unsigned lit_pos(int unsigned var_idx, pol_e pol);
    return LIT_STRIDE * var_idx + int'(pol);
  endfunction
endpackage

// File: rtl/pal_fuse_chain.sv
module pal_fuse_chain #(
  parameter int unsigned N_FUSE = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_bit,
  output logic [N_FUSE-1:0] fuses
);
  logic take;

  assign cfg_ready = !rst;
  assign take      = cfg_valid && cfg_ready;

  // Map storage is not cleared by reset: only the stream changes it.
  always_ff @(posedge clk) begin
    if (take) fuses <= {fuses[N_FUSE-2:0], cfg_bit};
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_valid && cfg_ready) |=> $stable(fuses));
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_ready) |=> (fuses[0] == $past(cfg_bit)));
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int unsigned N_VAR = 16,
  parameter int unsigned N_PT  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PT*2*N_VAR-1:0]    fuses,
  input  logic [N_VAR-1:0]           vars,
  output logic [N_PT-1:0]            pt
);
  import pal_pkg::*;
  localparam int unsigned PT_W = LIT_STRIDE * N_VAR;

  logic [PT_W-1:0] lit;

  for (genvar v = 0; v < N_VAR; v++) begin : g_lit
    assign lit[LIT_STRIDE*v + int'(POL_TRUE)] = vars[v];
    assign lit[LIT_STRIDE*v + int'(POL_COMP)] = ~vars[v];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [PT_W-1:0] sel;
    assign sel   = fuses[t*PT_W +: PT_W];
    // A term with no literal selected is held at 0 so unused terms drop out.
    assign pt[t] = (|sel) & (&(lit | ~sel));

    p_empty_pt_r4: assert property (@(posedge clk) disable iff (rst)
      (sel == '0) |-> !pt[t]);
    p_contra_r4: assert property (@(posedge clk) disable iff (rst)
      (sel[1:0] == 2'b11) |-> !pt[t]);
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int unsigned N_TERMS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TERMS-1:0] terms,
  output logic               q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= |terms;
  end

  p_clear_r7: assert property (@(posedge clk) rst |=> !q);
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (terms == '0) |=> !q);
  p_one_r5: assert property (@(posedge clk) disable iff (rst)
    (|terms) |=> q);
endmodule

// File: rtl/pal_reg_array.sv
module pal_reg_array #(
  parameter int unsigned N_IN       = 8,
  parameter int unsigned N_OUT      = 8,
  parameter int unsigned PT_PER_OUT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  in_pins,
  input  logic             oe_n,
  output logic [N_OUT-1:0] pin_n,
  output logic             pin_oe
);
  localparam int unsigned N_VAR  = N_IN + N_OUT;
  localparam int unsigned PT_W   = pal_pkg::LIT_STRIDE * N_VAR;
  localparam int unsigned N_PT   = N_OUT * PT_PER_OUT;
  localparam int unsigned N_FUSE = N_PT * PT_W;

  logic [N_FUSE-1:0] fuses;
  logic [N_PT-1:0]   pt;
  logic [N_OUT-1:0]  q;
  logic [N_VAR-1:0]  vars;

  pal_fuse_chain #(.N_FUSE(N_FUSE)) u_chain (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .fuses(fuses)
  );

  // Feedback: register Q values occupy the upper variable slots.
  assign vars = {q, in_pins};

  pal_and_plane #(.N_VAR(N_VAR), .N_PT(N_PT)) u_plane (
    .clk(clk), .rst(rst), .fuses(fuses), .vars(vars), .pt(pt)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    pal_macrocell #(.N_TERMS(PT_PER_OUT)) u_mc (
      .clk(clk), .rst(rst),
      .terms(pt[o*PT_PER_OUT +: PT_PER_OUT]),
      .q(q[o])
    );
  end

  assign pin_n  = ~q;
  assign pin_oe = ~oe_n;

  p_pins_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_n == ~q));
endmodule

// File: tb/pal_reg_array_test.sv
module pal_reg_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8, NO = 8, NP = 8;
  localparam int NV = NI + NO;
  localparam int PW = 2 * NV;
  localparam int NF = NO * NP * PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic cfg_bit = 1'b0;
  logic [NI-1:0] in_pins = '0;
  logic oe_n = 1'b0;
  logic cfg_ready;
  logic [NO-1:0] pin_n;
  logic pin_oe;

  int vectors = 0;
  int miscompares = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  logic [NF-1:0] mf = '0;
  logic [NO-1:0] mq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_reg_array #(.N_IN(NI), .N_OUT(NO), .PT_PER_OUT(NP)) uut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .in_pins(in_pins), .oe_n(oe_n),
    .pin_n(pin_n), .pin_oe(pin_oe)
  );

  function automatic logic [NO-1:0] model_next(logic [NF-1:0] f,
                                               logic [NI-1:0] i,
                                               logic [NO-1:0] q);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++) begin
      for (int p = 0; p < NP; p++) begin
        int base = (o * NP + p) * PW;
        bit any = 0;
        bit val = 1;
        for (int v = 0; v < NV; v++) begin
          logic x = (v < NI) ? i[v] : q[v-NI];
          if (f[base + 2*v])     begin any = 1; if (!x) val = 0; end
          if (f[base + 2*v + 1]) begin any = 1; if (x)  val = 0; end
        end
        if (any && val) r[o] = 1'b1;
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    logic [NO-1:0] nq;
    nq = model_next(mf, in_pins, mq);
    if (!rst && cfg_valid) mf = {mf[NF-2:0], cfg_bit};
    mq = rst ? '0 : nq;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R1 cfg_ready", {7'b0, cfg_ready}, {7'b0, !rst});
    if (armed) begin
      chk("R6 pin_n vs model", pin_n, ~mq);
      chk("R8 pin_oe", {7'b0, pin_oe}, {7'b0, !oe_n});
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_map(logic [NF-1:0] m, bit gaps);
    for (int i = NF - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 5 == 0)) begin
        cfg_valid = 1'b0;
        cfg_bit = 1'($urandom);
        tick();
      end
      cfg_valid = 1'b1;
      cfg_bit = m[i];
      tick();
    end
    cfg_valid = 1'b0;
  endtask

  function automatic int fidx(int o, int p, int v, int c);
    return (o * NP + p) * PW + 2 * v + c;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [NF-1:0] m;
    repeat (3) tick();
    chk("R7 reset pins", pin_n, 8'hFF);
    chk("R1 ready low in reset", {7'b0, cfg_ready}, 8'h00);
    rst = 1'b0;
    load_map('0, 1'b0);
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    armed = 1'b1;

    // R4: empty map never sets any register
    for (int k = 0; k < 20; k++) begin in_pins = 8'($urandom); tick(); end
    chk("R4 empty terms", pin_n, 8'hFF);

    // R4: every literal in both polarities gives 0
    load_map('1, 1'b1);
    in_pins = 8'h5A; tick(); tick();
    chk("R4 contradictory terms", pin_n, 8'hFF);

    // R3 / R9: out0 term0 = ~in[2], out2 term0 = q[0]
    m = '0;
    m[fidx(0, 0, 2, 1)] = 1'b1;
    m[fidx(2, 0, NI + 0, 0)] = 1'b1;
    load_map(m, 1'b1);
    in_pins = 8'h04; tick(); tick();
    chk("R3 inverted literal false", pin_n, 8'hFF);
    in_pins = 8'h00; tick();
    chk("R3 inverted literal true", pin_n, 8'hFE);
    tick();
    chk("R9 true feedback literal", pin_n, 8'hFA);
    in_pins = 8'h04; tick();
    chk("R9 feedback follows state", pin_n, 8'hFB);

    // R5: group boundaries
    m = '0;
    m[fidx(1, 0, 0, 0)] = 1'b1;
    m[fidx(1, 7, 1, 0)] = 1'b1;
    m[fidx(0, 7, 3, 0)] = 1'b1;
    load_map(m, 1'b0);
    in_pins = 8'h01; tick();
    chk("R5 first term of out1", pin_n, 8'hFD);
    in_pins = 8'h02; tick();
    chk("R5 last term of out1", pin_n, 8'hFD);
    in_pins = 8'h08; tick();
    chk("R5 last term of out0", pin_n, 8'hFE);
    in_pins = 8'h00; tick();
    chk("R5 no term true", pin_n, 8'hFF);

    // R9: toggle registers q <= q ^ in
    m = '0;
    for (int o = 0; o < NO; o++) begin
      m[fidx(o, 0, o, 0)] = 1'b1;
      m[fidx(o, 0, NI + o, 1)] = 1'b1;
      m[fidx(o, 1, o, 1)] = 1'b1;
      m[fidx(o, 1, NI + o, 0)] = 1'b1;
    end
    load_map(m, 1'b1);
    rst = 1'b1; tick();
    chk("R7 reset with map loaded", pin_n, 8'hFF);
    rst = 1'b0; in_pins = 8'hFF; tick();
    chk("R9 toggle up", pin_n, 8'h00);
    tick();
    chk("R9 toggle down", pin_n, 8'hFF);
    in_pins = 8'h0F; tick();
    chk("R9 partial toggle", pin_n, 8'hF0);
    tick();
    chk("R9 partial toggle back", pin_n, 8'hFF);
    in_pins = 8'hFF; tick();
    rst = 1'b1; tick();
    chk("R7 mid-run reset", pin_n, 8'hFF);
    rst = 1'b0; tick();
    chk("R7 map retained", pin_n, 8'h00);
    oe_n = 1'b1; tick();
    chk("R8 drivers off", {7'b0, pin_oe}, 8'h00);
    chk("R8 state advances while off", pin_n, 8'hFF);
    tick();
    chk("R8 state advances again", pin_n, 8'h00);
    oe_n = 1'b0; tick();
    chk("R8 drivers on", {7'b0, pin_oe}, 8'h01);

    // R2 / R6: random sparse maps against the model
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < NF; i++) m[i] = ($urandom % 10 == 0);
      load_map(m, 1'b1);
      for (int k = 0; k < 300; k++) begin
        in_pins = 8'($urandom);
        oe_n = ($urandom % 4 == 0);
        rst = ($urandom % 50 == 0);
        tick();
      end
      rst = 1'b0;
    end

    done = 1'b1;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule